// File: doc/BRIEF.md
# Radio State Sequencer

This block sequences the operating modes of a low-power radio transceiver: sleep, off, synthesizer-ready, receive and transmit. Software or a higher-level controller sends mode commands through a 3-bit command port qualified by a valid bit. A single strobe input acts on the current mode: it puts the off radio to sleep, wakes a sleeping radio, or starts a transmission from synthesizer-ready.

Every move between modes waits out a settling delay before the new mode is reported. Most delays are counted in microseconds, derived from the system clock frequency given as a parameter. Sleep entry is counted in periods of the radio's output clock, whose frequency is a second parameter. While a move is in progress the block reports a distinct in-transition code and raises a busy flag. Two forcing commands can abort a move in progress, but only from the modes where they are allowed. Arrival in the off mode from sleep produces a one-cycle wake interrupt.

Top module: `radio_state_seq`

## Requirements
- R1: After `rst_n` is released the block is in transition (code 7, busy high) for exactly 37 µs, then reports OFF (code 1). No wake interrupt is raised.
- R2: `state_code` encodes SLEEP=0, OFF=1, PLL-ready=2, RX=3, TX=4, in-transition=7. `busy` is high exactly while the code is 7. A delay of N units keeps code 7 visible for exactly N unit periods, counted from the clock edge that accepts the request.
- R3: In OFF, command 2 moves to PLL-ready and command 3 moves to RX. Each move takes 110 µs.
- R4: In PLL-ready or RX, command 1 moves to OFF in 1 µs. Command 3 from PLL-ready and command 2 from RX switch between the two in 1 µs.
- R5: A strobe in OFF with `cmd_valid` low moves to SLEEP after 35 output-clock periods. One period is CLK_HZ/OUTCLK_HZ clock cycles.
- R6: A strobe in SLEEP with `cmd_valid` low moves to OFF after 240 µs. `wake_irq` pulses for one cycle, in the cycle the code becomes OFF.
- R7: In PLL-ready, command 4 or a strobe starts a 16 µs ramp. TX (code 4) is then shown for `frame_len` µs, with `frame_len` sampled at the start and 0 treated as 1. A 32 µs move back to PLL-ready follows.
- R8: Command 5 (force off) starts a 1 µs move to OFF, aborting any move or frame in progress. It is ignored when the origin is SLEEP. The origin is the mode last left, and it stays unchanged across a forced abort.
- R9: Command 6 (force PLL-ready) starts a 1 µs move to PLL-ready when the origin is PLL-ready, RX or TX. It is ignored when the origin is SLEEP, OFF or the reset start-up.
- R10: While busy and during the TX frame, non-forcing commands and the strobe have no effect. Commands not listed for the current mode, and codes 0 and 7, have no effect.
- R11: When `cmd_valid` and the strobe are high in the same cycle, only the command is considered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command qualifier |
| cmd | input | 3 | Command code |
| slp_tx_strobe | input | 1 | Sleep / wake / transmit strobe |
| frame_len | input | FRAME_W | Transmit frame length in µs |
| state_code | output | 3 | Current mode or in-transition code |
| busy | output | 1 | High while a move is settling |
| wake_irq | output | 1 | One-cycle pulse on arrival in OFF from SLEEP |

## Verification
The bench aborts a 110 µs lock with a forced off part-way through. A design that kept the old timer would finish the lock late or land in the wrong mode. It sends force commands from origins where they must be ignored: force PLL-ready during a lock from OFF, and force off during a wake. A design that judged the origin by the destination would shorten those moves. It also drives command and strobe together, measures each frame length including the zero case, and checks that the wake pulse falls on the arrival cycle only. An early or stretched pulse, an off-by-one settle count, or a frame of zero length would each show up against the cycle-level model.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

   typedef enum logic [2:0] {
      ST_SLEEP = 3'd0,
      ST_OFF   = 3'd1,
      ST_PLL   = 3'd2,
      ST_RX    = 3'd3,
      ST_TX    = 3'd4,
      ST_BOOT  = 3'd5
   } rstate_e;

   localparam logic [2:0] CODE_MOVING = 3'd7;

   typedef enum logic [2:0] {
      CMD_NONE      = 3'd0,
      CMD_OFF       = 3'd1,
      CMD_PLL       = 3'd2,
      CMD_RX        = 3'd3,
      CMD_TX        = 3'd4,
      CMD_FORCE_OFF = 3'd5,
      CMD_FORCE_PLL = 3'd6,
      CMD_SPARE     = 3'd7
   } cmd_e;

   typedef enum logic {
      UNIT_US   = 1'b0,
      UNIT_OCLK = 1'b1
   } unit_e;

   typedef enum logic [2:0] {
      DLY_LOCK  = 3'd0,
      DLY_HOP   = 3'd1,
      DLY_RAMP  = 3'd2,
      DLY_SLEEP = 3'd3,
      DLY_WAKE  = 3'd4
   } dly_e;

   typedef struct packed {
      logic    go;
      rstate_e dst;
      dly_e    dly;
   } move_req_s;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rss_settle_timer.sv
module rss_settle_timer
   import radio_seq_pkg::*;
#(
   parameter int US_CYC   = 125,
   parameter int OCLK_CYC = 125,
   parameter int CNT_W    = 10,
   parameter int BOOT_N   = 37
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  unit_e            load_unit,
   input  logic [CNT_W-1:0] load_n,
   output logic             expire
);

   localparam int PRE_MAX = max2(US_CYC, OCLK_CYC);
   localparam int PRE_W   = (PRE_MAX > 1) ? $clog2(PRE_MAX) : 1;

   logic             run_q;
   logic [CNT_W-1:0] rem_q;
   logic             pre_zero;

   generate
      if (PRE_MAX == 1) begin : g_no_pre
         assign pre_zero = 1'b1;
      end else begin : g_pre
         logic [PRE_W-1:0] pre_q;
         unit_e            unit_q;

         function automatic logic [PRE_W-1:0] reload(input unit_e u);
            return (u == UNIT_OCLK) ? PRE_W'(OCLK_CYC - 1) : PRE_W'(US_CYC - 1);
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q  <= PRE_W'(US_CYC - 1);
               unit_q <= UNIT_US;
            end else if (load) begin
               pre_q  <= reload(load_unit);
               unit_q <= load_unit;
            end else if (run_q) begin
               pre_q  <= pre_zero ? reload(unit_q) : pre_q - 1'b1;
            end
         end

         assign pre_zero = (pre_q == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b1;
         rem_q <= CNT_W'(BOOT_N - 1);
      end else if (load) begin
         run_q <= 1'b1;
         rem_q <= load_n - 1'b1;
      end else if (run_q && pre_zero) begin
         if (rem_q == '0) run_q <= 1'b0;
         else             rem_q <= rem_q - 1'b1;
      end
   end

   assign expire = run_q && pre_zero && (rem_q == '0);

endmodule

// File: rtl/rss_cmd_decode.sv
module rss_cmd_decode
   import radio_seq_pkg::*;
(
   input  rstate_e   origin,
   input  logic      moving,
   input  logic      cmd_valid,
   input  logic [2:0] cmd,
   input  logic      strobe,
   output move_req_s req
);

   cmd_e c;
   logic solo_strobe;

   assign c           = cmd_e'(cmd);
   assign solo_strobe = strobe && !cmd_valid;

   always_comb begin
      req = '{go: 1'b0, dst: ST_OFF, dly: DLY_HOP};
      if (cmd_valid && c == CMD_FORCE_OFF && origin != ST_SLEEP) begin
         req = '{go: 1'b1, dst: ST_OFF, dly: DLY_HOP};
      end else if (cmd_valid && c == CMD_FORCE_PLL &&
                   (origin == ST_PLL || origin == ST_RX || origin == ST_TX)) begin
         req = '{go: 1'b1, dst: ST_PLL, dly: DLY_HOP};
      end else if (!moving) begin
         case (origin)
            ST_OFF: begin
               if (cmd_valid && c == CMD_PLL)
                  req = '{go: 1'b1, dst: ST_PLL, dly: DLY_LOCK};
               else if (cmd_valid && c == CMD_RX)
                  req = '{go: 1'b1, dst: ST_RX, dly: DLY_LOCK};
               else if (solo_strobe)
                  req = '{go: 1'b1, dst: ST_SLEEP, dly: DLY_SLEEP};
            end
            ST_PLL: begin
               if (cmd_valid && c == CMD_OFF)
                  req = '{go: 1'b1, dst: ST_OFF, dly: DLY_HOP};
               else if (cmd_valid && c == CMD_RX)
                  req = '{go: 1'b1, dst: ST_RX, dly: DLY_HOP};
               else if ((cmd_valid && c == CMD_TX) || solo_strobe)
                  req = '{go: 1'b1, dst: ST_TX, dly: DLY_RAMP};
            end
            ST_RX: begin
               if (cmd_valid && c == CMD_OFF)
                  req = '{go: 1'b1, dst: ST_OFF, dly: DLY_HOP};
               else if (cmd_valid && c == CMD_PLL)
                  req = '{go: 1'b1, dst: ST_PLL, dly: DLY_HOP};
            end
            ST_SLEEP: begin
               if (solo_strobe)
                  req = '{go: 1'b1, dst: ST_OFF, dly: DLY_WAKE};
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/radio_state_seq.sv
module radio_state_seq
   import radio_seq_pkg::*;
#(
   parameter int CLK_HZ       = 125_000_000,
   parameter int OUTCLK_HZ    = 1_000_000,
   parameter int FRAME_W      = 10,
   parameter int T_RST_US     = 37,
   parameter int T_WAKE_US    = 240,
   parameter int T_SLEEP_OCLK = 35,
   parameter int T_LOCK_US    = 110,
   parameter int T_HOP_US     = 1,
   parameter int T_RAMP_US    = 16,
   parameter int T_RET_US     = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd,
   input  logic               slp_tx_strobe,
   input  logic [FRAME_W-1:0] frame_len,
   output logic [2:0]         state_code,
   output logic               busy,
   output logic               wake_irq
);

   localparam int US_CYC   = CLK_HZ / 1_000_000;
   localparam int OCLK_CYC = CLK_HZ / OUTCLK_HZ;
   localparam int MAX_T    = max2(max2(max2(T_RST_US, T_WAKE_US), max2(T_SLEEP_OCLK, T_LOCK_US)),
                                  max2(max2(T_HOP_US, T_RAMP_US), max2(T_RET_US, (1 << FRAME_W) - 1)));
   localparam int CNT_W    = $clog2(MAX_T + 1);

   generate
      if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
         $error("CLK_HZ must be a whole multiple of 1 MHz");
      end
      if (OUTCLK_HZ <= 0 || OUTCLK_HZ > CLK_HZ || (CLK_HZ % OUTCLK_HZ) != 0) begin : g_bad_oclk
         $error("OUTCLK_HZ must divide CLK_HZ");
      end
      if (FRAME_W < 1 || FRAME_W > 16) begin : g_bad_frame
         $error("FRAME_W out of range");
      end
      if (T_RST_US < 1 || T_WAKE_US < 1 || T_SLEEP_OCLK < 1 || T_LOCK_US < 1 ||
          T_HOP_US < 1 || T_RAMP_US < 1 || T_RET_US < 1) begin : g_bad_delay
         $error("every settling delay must be at least one unit");
      end
   endgenerate

   rstate_e            cur_q, dst_q;
   logic               moving_q, wake_q;
   logic [FRAME_W-1:0] frame_q, frame_eff;
   move_req_s          req;
   logic               tmr_expire, tmr_load, auto_load;
   logic               frame_phase, return_phase;
   unit_e              tmr_unit;
   logic [CNT_W-1:0]   tmr_n;

   rss_cmd_decode u_decode (
      .origin    (cur_q),
      .moving    (moving_q),
      .cmd_valid (cmd_valid),
      .cmd       (cmd),
      .strobe    (slp_tx_strobe),
      .req       (req)
   );

   function automatic logic [CNT_W-1:0] dly_count(input dly_e d);
      case (d)
         DLY_LOCK:  return CNT_W'(T_LOCK_US);
         DLY_RAMP:  return CNT_W'(T_RAMP_US);
         DLY_SLEEP: return CNT_W'(T_SLEEP_OCLK);
         DLY_WAKE:  return CNT_W'(T_WAKE_US);
         default:   return CNT_W'(T_HOP_US);
      endcase
   endfunction

   assign frame_eff    = (frame_len == '0) ? FRAME_W'(1) : frame_len;
   assign frame_phase  = moving_q && (dst_q == ST_TX);
   assign return_phase = !moving_q && (cur_q == ST_TX);
   assign auto_load    = tmr_expire && !req.go && (frame_phase || return_phase);
   assign tmr_load     = req.go || auto_load;

   always_comb begin
      if (req.go) begin
         tmr_n    = dly_count(req.dly);
         tmr_unit = (req.dly == DLY_SLEEP) ? UNIT_OCLK : UNIT_US;
      end else if (frame_phase) begin
         tmr_n    = CNT_W'(frame_q);
         tmr_unit = UNIT_US;
      end else begin
         tmr_n    = CNT_W'(T_RET_US);
         tmr_unit = UNIT_US;
      end
   end

   rss_settle_timer #(
      .US_CYC   (US_CYC),
      .OCLK_CYC (OCLK_CYC),
      .CNT_W    (CNT_W),
      .BOOT_N   (T_RST_US)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (tmr_load),
      .load_unit (tmr_unit),
      .load_n    (tmr_n),
      .expire    (tmr_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q    <= ST_BOOT;
         dst_q    <= ST_OFF;
         moving_q <= 1'b1;
         frame_q  <= FRAME_W'(1);
         wake_q   <= 1'b0;
      end else begin
         wake_q <= 1'b0;
         if (req.go) begin
            moving_q <= 1'b1;
            dst_q    <= req.dst;
            if (req.dst == ST_TX) frame_q <= frame_eff;
         end else if (tmr_expire) begin
            if (moving_q) begin
               cur_q    <= dst_q;
               moving_q <= 1'b0;
               wake_q   <= (cur_q == ST_SLEEP) && (dst_q == ST_OFF);
            end else if (cur_q == ST_TX) begin
               moving_q <= 1'b1;
               dst_q    <= ST_PLL;
            end
         end
      end
   end

   assign state_code = moving_q ? CODE_MOVING : 3'(cur_q);
   assign busy       = moving_q;
   assign wake_irq   = wake_q;

endmodule

// File: rtl/radio_state_seq_chk.sv
module radio_state_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [2:0] cmd,
   input logic       slp_tx_strobe,
   input logic [2:0] state_code,
   input logic       busy,
   input logic       wake_irq
);

   p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code <= 3'd4) || (state_code == 3'd7));

   p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |=> !wake_irq);

   p_irq_on_arrival_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_irq |-> (state_code == 3'd1) && ($past(state_code) == 3'd7));

   p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd0 && !(slp_tx_strobe && !cmd_valid)) |=> (state_code == 3'd0));

   p_force_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd == 3'd5 && state_code >= 3'd1 && state_code <= 3'd4) |=> busy);

   p_force_pll_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd1 && cmd_valid && cmd == 3'd6) |=> (state_code == 3'd1));

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code >= 3'd1 && state_code <= 3'd3 && !cmd_valid && !slp_tx_strobe)
         |=> $stable(state_code));

endmodule

bind radio_state_seq radio_state_seq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_valid     (cmd_valid),
   .cmd           (cmd),
   .slp_tx_strobe (slp_tx_strobe),
   .state_code    (state_code),
   .busy          (busy),
   .wake_irq      (wake_irq)
);

// File: tb/radio_state_seq_bench.sv
module radio_state_seq_bench;

   localparam int P  = 125;
   localparam int OP = 125;
   localparam int FW = 10;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cmd_valid;
   logic [2:0]    cmd;
   logic          strb;
   logic [FW-1:0] frame_len;
   logic [2:0]    state_code;
   logic          busy;
   logic          wake_irq;

   int    checks = 0;
   int    failures = 0;
   bit    done = 1'b0;
   string tag = "R1";

   always #4 clk = ~clk;

   radio_state_seq u_radio_state_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .cmd_valid     (cmd_valid),
      .cmd           (cmd),
      .slp_tx_strobe (strb),
      .frame_len     (frame_len),
      .state_code    (state_code),
      .busy          (busy),
      .wake_irq      (wake_irq)
   );

   // behavioural reference: modes 0..4, 5 = start-up origin
   int m_cur, m_dst, m_left, m_frame;
   bit m_moving, m_run, m_irq;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cur = 5; m_dst = 1; m_moving = 1; m_run = 1;
         m_left = 37 * P; m_irq = 0; m_frame = 1;
      end else begin
         bit go; int gd; int gn; bit exp_now; bit solo;
         go = 0; gd = 0; gn = 0;
         solo = strb && !cmd_valid;
         exp_now = m_run && (m_left == 1);
         if (cmd_valid && cmd == 5 && m_cur != 0) begin
            go = 1; gd = 1; gn = P;
         end else if (cmd_valid && cmd == 6 && (m_cur == 2 || m_cur == 3 || m_cur == 4)) begin
            go = 1; gd = 2; gn = P;
         end else if (!m_moving) begin
            if (m_cur == 1) begin
               if (cmd_valid && cmd == 2)      begin go = 1; gd = 2; gn = 110 * P; end
               else if (cmd_valid && cmd == 3) begin go = 1; gd = 3; gn = 110 * P; end
               else if (solo)                  begin go = 1; gd = 0; gn = 35 * OP; end
            end else if (m_cur == 2) begin
               if (cmd_valid && cmd == 1)      begin go = 1; gd = 1; gn = P; end
               else if (cmd_valid && cmd == 3) begin go = 1; gd = 3; gn = P; end
               else if ((cmd_valid && cmd == 4) || solo) begin go = 1; gd = 4; gn = 16 * P; end
            end else if (m_cur == 3) begin
               if (cmd_valid && cmd == 1)      begin go = 1; gd = 1; gn = P; end
               else if (cmd_valid && cmd == 2) begin go = 1; gd = 2; gn = P; end
            end else if (m_cur == 0) begin
               if (solo) begin go = 1; gd = 1; gn = 240 * P; end
            end
         end
         m_irq = 0;
         if (go) begin
            m_moving = 1; m_dst = gd; m_left = gn; m_run = 1;
            if (gd == 4) m_frame = (frame_len == 0) ? 1 : int'(frame_len);
         end else if (exp_now) begin
            if (m_moving) begin
               m_irq = (m_cur == 0 && m_dst == 1);
               m_cur = m_dst; m_moving = 0;
               if (m_cur == 4) begin m_left = m_frame * P; m_run = 1; end
               else m_run = 0;
            end else begin
               m_moving = 1; m_dst = 2; m_left = 32 * P; m_run = 1;
            end
         end else if (m_run) begin
            m_left = m_left - 1;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n === 1'b1 && !done) begin
         int ec;
         ec = m_moving ? 7 : m_cur;
         checks++;
         if (state_code !== 3'(ec) || busy !== m_moving || wake_irq !== m_irq) begin
            failures++;
            $display("FAIL %s model: code=%0d busy=%0b irq=%0b expected code=%0d busy=%0b irq=%0b",
                     tag, state_code, busy, wake_irq, ec, m_moving, m_irq);
         end
      end
   end

   task automatic check_eq(input int act, input int exp, input string req, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input bit cv, input int c, input bit s);
      @(negedge clk);
      cmd_valid = cv; cmd = 3'(c); strb = s;
      @(negedge clk);
      cmd_valid = 0; cmd = 0; strb = 0;
   endtask

   task automatic measure_inj(input int exp, input string req, input int inj_at, input int inj_cmd);
      int n;
      n = 0;
      while (busy === 1'b1 && n < 40000) begin
         if (n == inj_at) begin cmd_valid = 1; cmd = 3'(inj_cmd); end
         else begin cmd_valid = 0; cmd = 0; end
         n++;
         @(negedge clk);
      end
      cmd_valid = 0; cmd = 0;
      check_eq(n, exp, req, "busy cycles");
   endtask

   task automatic measure_busy(input int exp, input string req);
      measure_inj(exp, req, -1, 0);
   endtask

   task automatic count_code(input int code, input int exp, input string req);
      int n;
      n = 0;
      while (state_code === 3'(code) && n < 40000) begin
         n++;
         @(negedge clk);
      end
      check_eq(n, exp, req, "mode cycles");
   endtask

   task automatic check_idle(input int code, input string req);
      repeat (3) @(negedge clk);
      check_eq(int'(state_code), code, req, "code after ignored input");
      check_eq(int'(busy), 0, req, "busy after ignored input");
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst_n = 0; cmd_valid = 0; cmd = 0; strb = 0; frame_len = 3;
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1 start-up
      tag = "R1";
      check_eq(int'(state_code), 7, "R2", "code during start-up");
      check_eq(int'(busy), 1, "R1", "busy during start-up");
      measure_busy(37 * P, "R1");
      check_eq(int'(state_code), 1, "R1", "code after start-up");
      check_eq(int'(wake_irq), 0, "R1", "no wake pulse at start-up");

      // R10 / R9 ignored inputs in OFF
      tag = "R10";
      drive(1, 7, 0); check_idle(1, "R10");
      drive(1, 0, 0); check_idle(1, "R10");
      drive(1, 4, 0); check_idle(1, "R10");
      tag = "R9";
      drive(1, 6, 0); check_idle(1, "R9");

      // R5 sleep entry, R8/R11 ignored in sleep, R6 wake
      tag = "R5";
      drive(0, 0, 1);
      measure_busy(35 * OP, "R5");
      check_eq(int'(state_code), 0, "R5", "sleep code");
      tag = "R8";
      drive(1, 5, 0); check_idle(0, "R8");
      tag = "R11";
      drive(1, 1, 1); check_idle(0, "R11");
      tag = "R6";
      drive(0, 0, 1);
      measure_inj(240 * P, "R6", 50 * P, 5);
      check_eq(int'(state_code), 1, "R6", "code after wake");
      check_eq(int'(wake_irq), 1, "R6", "wake pulse on arrival");
      @(negedge clk);
      check_eq(int'(wake_irq), 0, "R6", "wake pulse width");

      // R11 command wins over strobe, R3 lock
      tag = "R11";
      drive(1, 2, 1);
      measure_busy(110 * P, "R11");
      check_eq(int'(state_code), 2, "R3", "PLL-ready after lock");

      // R4 fast hops
      tag = "R4";
      drive(1, 3, 0); measure_busy(P, "R4"); check_eq(int'(state_code), 3, "R4", "RX");
      drive(1, 2, 0); measure_busy(P, "R4"); check_eq(int'(state_code), 2, "R4", "PLL-ready");
      drive(1, 1, 0); measure_busy(P, "R4"); check_eq(int'(state_code), 1, "R4", "OFF");

      // R3 lock to RX with an ignored command mid-way (R10)
      tag = "R3";
      drive(1, 3, 0);
      measure_inj(110 * P, "R10", 10 * P, 2);
      check_eq(int'(state_code), 3, "R3", "RX after lock");
      drive(1, 1, 0); measure_busy(P, "R4");

      // R8 forced abort of a lock
      tag = "R8";
      drive(1, 2, 0);
      measure_inj(20 * P + 1 + P, "R8", 20 * P, 5);
      check_eq(int'(state_code), 1, "R8", "OFF after forced abort");

      // R9 force PLL ignored while origin is OFF
      tag = "R9";
      drive(1, 2, 0);
      measure_inj(110 * P, "R9", 30 * P, 6);
      check_eq(int'(state_code), 2, "R9", "lock unaffected");

      // R7 transmit by strobe
      tag = "R7";
      frame_len = 3;
      drive(0, 0, 1);
      measure_busy(16 * P, "R7");
      count_code(4, 3 * P, "R7");
      measure_busy(32 * P, "R7");
      check_eq(int'(state_code), 2, "R7", "back to PLL-ready");

      // R7 zero-length frame by command
      frame_len = 0;
      drive(1, 4, 0);
      measure_busy(16 * P, "R7");
      count_code(4, P, "R7");
      measure_busy(32 * P, "R7");
      check_eq(int'(state_code), 2, "R7", "back to PLL-ready");

      // R9 force PLL aborts the ramp
      tag = "R9";
      frame_len = 2;
      drive(1, 4, 0);
      measure_inj(5 * P + 1 + P, "R9", 5 * P, 6);
      check_eq(int'(state_code), 2, "R9", "PLL-ready after forced abort");

      // R10 command ignored in frame, R8 force off from frame
      tag = "R10";
      frame_len = 20;
      drive(1, 4, 0);
      measure_busy(16 * P, "R7");
      repeat (3) @(negedge clk);
      drive(1, 1, 0);
      check_eq(int'(state_code), 4, "R10", "frame continues");
      tag = "R8";
      drive(1, 5, 0);
      measure_busy(P, "R8");
      check_eq(int'(state_code), 1, "R8", "OFF after forced stop");

      repeat (4) @(negedge clk);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule